// File: doc/BRIEF.md
# Triangle-Wave Tone Channel

This block produces a stream of 4-bit samples that trace a symmetric triangle. A programmable period timer, clocked by a CPU-rate enable, emits one pulse every N+1 enabled cycles. Each pulse steps a 5-bit counter. The counter's top bit folds its four low bits into a down ramp followed by an up ramp. A sample therefore repeats once at each turning point, and one triangle period spans 32 timer pulses.

Two independent counters decide whether the sequencer may move. The first is a 7-bit linear counter, clocked by a quarter-frame tick. It has a reload mode and a countdown mode, and its mode depends on the order in which software writes the registers. The second is a 7-bit length counter, clocked by a half-frame tick. It is loaded from a 5-bit index through a fixed lookup and can be forced to zero with a channel-enable level. When either counter reaches zero, the sequencer holds its current step. The sample then freezes instead of returning to a fixed level.

Software programs the block through one byte-wide write port with a 2-bit register select. The surrounding frame sequencer supplies the two tick inputs.

Top module: `tri_wave_gen`

## Requirements
- R1: The period timer counts down on each enabled cycle (`cpu_ce`=1). On the enabled cycle where it reads zero, it reloads with the period N and emits a pulse, giving one pulse every N+1 enabled cycles. The reset count is 0. Each pulse advances the step counter by one, modulo 32, while both gating counters are nonzero.
- R2: For step s, `sample_o` is 15-s when s<16 and s-16 when s>=16. This gives the sequence 15,14,...,0,0,1,...,15.
- R3: While the linear count or the length count is zero, the step counter keeps its value. Reset clears the step to 0 (sample 15), the length count to 0 and the linear count to 0, and selects count mode.
- R4: In count mode, each `qtr_tick` decrements a nonzero linear count by one. A zero linear count stays at zero.
- R5: In reload mode, the linear count copies control bits 6:0 on every cycle, including a value written to the control register in that cycle. `qtr_tick` has no effect in this mode.
- R6: A write to the period-high register (select 2) loads the linear count from control bits 6:0. It then leaves the counter in reload mode if control bit 7 is 1, or in count mode if it is 0.
- R7: A control write (select 0) made in count mode keeps count mode. A control write made in reload mode keeps reload mode only when the new bit 7 is 1.
- R8: Each `half_tick` decrements a nonzero length count by one, unless control bit 7 is 1. A zero length count stays at zero.
- R9: A period-high write loads the length count from data bits 7:3, using the following lookup.
  - When bit 3 is 1, a value k in bits 7:4 loads k, and k=0 loads 127.
  - When bit 3 is 0 and bit 7 is 0, bits 6:4 = 0..7 load 5,10,20,40,80,30,7,14.
  - When bit 3 is 0 and bit 7 is 1, bits 6:4 = 0..7 load 6,12,24,48,96,36,8,16.
  - The same write also loads bits 2:0 into period bits 10:8.
- R10: While `chan_en` is 0, the length count is forced to 0 and period-high writes do not load it. Raising `chan_en` loads nothing.
- R11: Select 1 writes period bits 7:0 and select 0 writes the control byte. Select 3 changes nothing.
- R12: `len_active_o` is 1 exactly when the length count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | Enable that advances the period timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period low, 2 period high and length index, 3 unused |
| wr_data | input | 8 | Write data |
| chan_en | input | 1 | Channel enable level; 0 forces the length count to zero |
| qtr_tick | input | 1 | Quarter-frame tick for the linear counter |
| half_tick | input | 1 | Half-frame tick for the length counter |
| sample_o | output | STEP_W-1 | Folded triangle sample |
| len_active_o | output | 1 | Length count is nonzero |

## Verification
The bench builds the block with its default widths: an 11-bit period and a 5-bit step counter. It programs periods of 0 and 3, so the timer fires every one to four cycles. A complete 32-step triangle then runs in about a hundred cycles and can be compared step by step against an arithmetic model.

The 5-bit length index is small enough to sweep all 32 codes, and each loaded count is drained tick by tick to confirm the lookup. The linear-counter mode rules are exercised as explicit write sequences. A long pseudo-random mix of writes, ticks and enable changes then reaches interleavings that the directed phases do not cover.

// File: rtl/tri_wave_pkg.sv
package tri_wave_pkg;

  localparam int LEN_W = 7;
  localparam int LIN_W = 7;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PER_LO = 2'd1,
    SEL_PER_HI = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  // idx[0] is data bit 3, idx[3:1] are data bits 6:4, idx[4] is data bit 7
  function automatic logic [LEN_W-1:0] len_decode(input logic [4:0] idx);
    logic [LEN_W-1:0] v;
    if (idx[0]) begin
      v = (idx[4:1] == 4'd0) ? 7'h7F : {3'b000, idx[4:1]};
    end else begin
      case ({idx[4], idx[3:1]})
        4'h0: v = 7'd5;
        4'h1: v = 7'd10;
        4'h2: v = 7'd20;
        4'h3: v = 7'd40;
        4'h4: v = 7'd80;
        4'h5: v = 7'd30;
        4'h6: v = 7'd7;
        4'h7: v = 7'd14;
        4'h8: v = 7'd6;
        4'h9: v = 7'd12;
        4'hA: v = 7'd24;
        4'hB: v = 7'd48;
        4'hC: v = 7'd96;
        4'hD: v = 7'd36;
        4'hE: v = 7'd8;
        default: v = 7'd16;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/tri_reg_bank.sv
module tri_reg_bank
  import tri_wave_pkg::*;
#(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctrl_q,
  output logic [PER_W-1:0] period_q,
  output logic             ctrl_wr,
  output logic             hi_wr
);
  localparam int HI_W = PER_W - 8;

  logic lo_wr;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign lo_wr   = wr_en && (wr_sel == SEL_PER_LO);
  assign hi_wr   = wr_en && (wr_sel == SEL_PER_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data;
      if (lo_wr)   period_q[7:0] <= wr_data;
      if (hi_wr)   period_q[PER_W-1:8] <= wr_data[HI_W-1:0];
    end
  end

endmodule

// File: rtl/tri_period_timer.sv
module tri_period_timer #(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [PER_W-1:0] period,
  output logic             tc_o
);
  logic [PER_W-1:0] cnt_q;

  assign tc_o = ce && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ce) begin
      if (cnt_q == '0) cnt_q <= period;
      else             cnt_q <= cnt_q - PER_W'(1);
    end
  end

endmodule

// File: rtl/tri_step_seq.sv
module tri_step_seq #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [STEP_W-2:0] sample_o
);
  localparam int OUT_W = STEP_W - 1;

  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst)      step_q <= '0;
    else if (adv) step_q <= step_q + STEP_W'(1);
  end

  // fold: top bit selects between the inverted and plain low bits
  for (genvar i = 0; i < OUT_W; i++) begin : g_fold
    assign sample_o[i] = ~(step_q[i] ^ step_q[STEP_W-1]);
  end

endmodule

// File: rtl/tri_linear_ctr.sv
module tri_linear_ctr
  import tri_wave_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_wr,
  input  logic             ctrl_wr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       ctrl_q,
  input  logic             qtr_tick,
  output logic [LIN_W-1:0] cnt_o,
  output logic             load_o,
  output logic             nz_o
);
  logic [LIN_W-1:0] cnt_q;
  logic             load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
    end else if (hi_wr) begin
      cnt_q  <= ctrl_q[LIN_W-1:0];
      load_q <= ctrl_q[LIN_W];
    end else if (load_q) begin
      if (ctrl_wr) begin
        cnt_q  <= wr_data[LIN_W-1:0];
        load_q <= wr_data[LIN_W];
      end else begin
        cnt_q  <= ctrl_q[LIN_W-1:0];
      end
    end else if (qtr_tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - LIN_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign nz_o   = (cnt_q != '0);

endmodule

// File: rtl/tri_length_ctr.sv
module tri_length_ctr
  import tri_wave_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  logic       hi_wr,
  input  logic [4:0] len_idx,
  input  logic       halt,
  input  logic       half_tick,
  output logic       nz_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst || !chan_en) begin
      len_q <= '0;
    end else if (hi_wr) begin
      len_q <= len_decode(len_idx);
    end else if (half_tick && !halt && (len_q != '0)) begin
      len_q <= len_q - LEN_W'(1);
    end
  end

  assign nz_o = (len_q != '0);

endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
  import tri_wave_pkg::*;
#(
  parameter int PER_W  = 11,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              chan_en,
  input  logic              qtr_tick,
  input  logic              half_tick,
  output logic [STEP_W-2:0] sample_o,
  output logic              len_active_o
);
  logic [7:0]       ctrl_q;
  logic [PER_W-1:0] period_q;
  logic             ctrl_wr;
  logic             hi_wr;
  logic             tc;
  logic [LIN_W-1:0] lin_cnt;
  logic             lin_load;
  logic             lin_nz;
  logic             len_nz;
  logic             step_adv;

  tri_reg_bank #(.PER_W(PER_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .period_q (period_q),
    .ctrl_wr  (ctrl_wr),
    .hi_wr    (hi_wr)
  );

  tri_period_timer #(.PER_W(PER_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .ce     (cpu_ce),
    .period (period_q),
    .tc_o   (tc)
  );

  tri_linear_ctr u_lin (
    .clk      (clk),
    .rst      (rst),
    .hi_wr    (hi_wr),
    .ctrl_wr  (ctrl_wr),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .qtr_tick (qtr_tick),
    .cnt_o    (lin_cnt),
    .load_o   (lin_load),
    .nz_o     (lin_nz)
  );

  tri_length_ctr u_len (
    .clk       (clk),
    .rst       (rst),
    .chan_en   (chan_en),
    .hi_wr     (hi_wr),
    .len_idx   (wr_data[7:3]),
    .halt      (ctrl_q[7]),
    .half_tick (half_tick),
    .nz_o      (len_nz)
  );

  assign step_adv = tc && lin_nz && len_nz;

  tri_step_seq #(.STEP_W(STEP_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .adv      (step_adv),
    .sample_o (sample_o)
  );

  assign len_active_o = len_nz;

endmodule

// File: rtl/tri_wave_gen_sva.sv
module tri_wave_gen_sva #(
  parameter int OUT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             len_active_o,
  input logic [OUT_W-1:0] sample_o,
  input logic [6:0]       lin_cnt,
  input logic             lin_load,
  input logic [6:0]       ctrl_reload
);
  logic hi_wr_s;
  logic ctrl_wr_s;
  assign hi_wr_s   = wr_en && (wr_sel == 2'd2);
  assign ctrl_wr_s = wr_en && (wr_sel == 2'd0);

  p_len_force_r10: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !len_active_o);

  p_len_no_self_load_r10: assert property (@(posedge clk) disable iff (rst)
    (!len_active_o && !hi_wr_s) |=> !len_active_o);

  p_hold_on_len_r3: assert property (@(posedge clk) disable iff (rst)
    !len_active_o |=> $stable(sample_o));

  p_hold_on_lin_r3: assert property (@(posedge clk) disable iff (rst)
    (lin_cnt == 7'd0) |=> $stable(sample_o));

  p_lin_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (lin_cnt == 7'd0 && !lin_load && !hi_wr_s) |=> (lin_cnt == 7'd0));

  p_lin_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (lin_load && !wr_en) |=> (lin_cnt == $past(ctrl_reload)));

  p_lin_reload_r6: assert property (@(posedge clk) disable iff (rst)
    hi_wr_s |=> (lin_cnt == $past(ctrl_reload)));

  p_count_mode_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (!lin_load && ctrl_wr_s) |=> !lin_load);

endmodule

bind tri_wave_gen tri_wave_gen_sva #(.OUT_W(STEP_W-1)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .chan_en      (chan_en),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .len_active_o (len_active_o),
  .sample_o     (sample_o),
  .lin_cnt      (lin_cnt),
  .lin_load     (lin_load),
  .ctrl_reload  (ctrl_q[6:0])
);

// File: tb/tri_wave_gen_bench.sv
module tri_wave_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       chan_en = 1'b0;
  logic       qtr_tick = 1'b0;
  logic       half_tick = 1'b0;
  logic [3:0] sample_o;
  logic       len_active_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_wave_gen u_tri_wave_gen (
    .clk          (clk),
    .rst          (rst),
    .cpu_ce       (cpu_ce),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .chan_en      (chan_en),
    .qtr_tick     (qtr_tick),
    .half_tick    (half_tick),
    .sample_o     (sample_o),
    .len_active_o (len_active_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R3";

  int       m_tmr, m_per, m_step, m_lin, m_len;
  bit       m_load;
  bit [7:0] m_ctrl;

  function automatic int exp_len(int idx);
    int k, sel, up;
    if (idx % 2 == 1) begin
      k = (idx / 2) % 16;
      return (k == 0) ? 127 : k;
    end
    sel = (idx / 2) % 8;
    up  = (idx / 16) % 2;
    if (sel < 5) return (up ? 6 : 5) << sel;
    if (sel == 5) return up ? 36 : 30;
    if (sel == 6) return up ? 8 : 7;
    return up ? 16 : 14;
  endfunction

  function automatic int exp_sample(int s);
    return (s < 16) ? 15 - s : s - 16;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit hw, cw, lw;
    int n_tmr, n_step, n_lin, n_len, n_per;
    bit n_load;
    bit [7:0] n_ctrl;
    hw = wr_en && wr_sel == 2'd2;
    cw = wr_en && wr_sel == 2'd0;
    lw = wr_en && wr_sel == 2'd1;
    n_tmr = m_tmr; n_step = m_step; n_lin = m_lin; n_len = m_len;
    n_load = m_load; n_ctrl = m_ctrl; n_per = m_per;
    if (cpu_ce) begin
      if (m_tmr == 0) begin
        n_tmr = m_per;
        if (m_lin != 0 && m_len != 0) n_step = (m_step + 1) % 32;
      end else n_tmr = m_tmr - 1;
    end
    if (hw) begin
      n_lin = m_ctrl % 128; n_load = m_ctrl[7];
    end else if (m_load) begin
      if (cw) begin n_lin = wr_data % 128; n_load = wr_data[7]; end
      else n_lin = m_ctrl % 128;
    end else if (qtr_tick && m_lin != 0) n_lin = m_lin - 1;
    if (!chan_en) n_len = 0;
    else if (hw) n_len = exp_len(wr_data / 8);
    else if (half_tick && !m_ctrl[7] && m_len != 0) n_len = m_len - 1;
    if (cw) n_ctrl = wr_data;
    if (lw) n_per = (m_per / 256) * 256 + wr_data;
    if (hw) n_per = (wr_data % 8) * 256 + (m_per % 256);
    m_tmr = n_tmr; m_step = n_step; m_lin = n_lin; m_len = n_len;
    m_load = n_load; m_ctrl = n_ctrl; m_per = n_per;
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst) begin
      m_tmr = 0; m_per = 0; m_step = 0; m_lin = 0; m_len = 0;
      m_load = 0; m_ctrl = 0;
    end else model_edge();
    @(negedge clk);
    if (!rst) begin
      check(tag, sample_o, exp_sample(m_step), "sample");
      check(tag, len_active_o, (m_len != 0) ? 1 : 0, "length status (R12)");
    end
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic wr(bit [1:0] sel, bit [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic qtick();
    qtr_tick = 1'b1; cyc(); qtr_tick = 1'b0;
  endtask

  task automatic htick();
    half_tick = 1'b1; cyc(); half_tick = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int n, changes;
    logic [3:0] prev;
    logic [15:0] lfsr;

    // reset state
    rst = 1'b1; cpu_ce = 1'b1;
    run(3);
    rst = 1'b0;
    tag = "R3";
    cyc();
    check("R3", sample_o, 15, "reset sample");
    check("R3", len_active_o, 0, "reset length status");

    // R9: sweep all 32 length codes and drain each with half ticks (R8 count)
    tag = "R9";
    chan_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      wr(2'd2, 8'(i << 3));
      check("R9", len_active_o, 1, "length loaded");
      n = 0;
      while (len_active_o && n < 200) begin htick(); n++; end
      check("R9", n, exp_len(i), "length drain ticks");
    end

    // R10: enable forces zero and reload is not restored
    tag = "R10";
    wr(2'd2, 8'h08);
    check("R10", len_active_o, 1, "loaded 127");
    chan_en = 1'b0; cyc();
    check("R10", len_active_o, 0, "forced by enable low");
    chan_en = 1'b1; run(2);
    check("R10", len_active_o, 0, "enable high loads nothing");
    chan_en = 1'b0; wr(2'd2, 8'h08);
    check("R10", len_active_o, 0, "write while disabled ignored");
    chan_en = 1'b1; cyc();

    // R1 / R2: walk the triangle with gated enable pattern
    tag = "R2";
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h08);
    for (int i = 0; i < 400; i++) begin
      cpu_ce = (i % 3) != 2;
      cyc();
    end
    cpu_ce = 1'b1;
    tag = "R1";
    run(8);
    changes = 0;
    prev = sample_o;
    for (int i = 0; i < 128; i++) begin
      cyc();
      if (sample_o != prev) changes++;
      prev = sample_o;
    end
    check("R1", changes, 30, "visible steps in 32 timer pulses");
    wr(2'd1, 8'd0);
    run(70);

    // R4: count mode decrement and floor
    tag = "R4";
    wr(2'd0, 8'h05);
    for (int i = 0; i < 7; i++) begin qtick(); run(9); end
    prev = sample_o;
    run(20);
    check("R4", sample_o, prev, "frozen after linear zero");

    // R7 / R5 mode rules
    tag = "R7";
    wr(2'd0, 8'h85);
    prev = sample_o;
    run(5);
    check("R7", sample_o, prev, "count mode kept, no reload");
    wr(2'd2, 8'h08);
    tag = "R5";
    wr(2'd0, 8'h83);
    for (int i = 0; i < 6; i++) begin qtick(); run(3); end
    prev = sample_o;
    cyc();
    check("R5", (sample_o != prev) ? 1 : 0, 1, "reload mode keeps sequencer running");
    tag = "R7";
    wr(2'd0, 8'h02);
    qtick(); run(4); qtick();
    prev = sample_o;
    run(10);
    check("R7", sample_o, prev, "count mode after 1 to 0 control write");

    // R6: period-high write with control bit 7 clear
    tag = "R6";
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h08);
    for (int i = 0; i < 5; i++) begin qtick(); run(5); end
    prev = sample_o;
    run(10);
    check("R6", sample_o, prev, "counted down after load");

    // R8: halt bit holds the length count
    tag = "R8";
    wr(2'd0, 8'h84);
    wr(2'd2, 8'h28);
    for (int i = 0; i < 5; i++) htick();
    check("R8", len_active_o, 1, "halted length kept");
    wr(2'd0, 8'h04);
    htick();
    check("R8", len_active_o, 1, "one tick left");
    htick();
    check("R8", len_active_o, 0, "reached zero");
    htick();
    check("R8", len_active_o, 0, "stays zero");

    // R11: spare select changes nothing
    tag = "R11";
    wr(2'd0, 8'h80);
    wr(2'd2, 8'h08);
    wr(2'd3, 8'h00);
    run(40);
    check("R11", len_active_o, 1, "spare write ignored");

    // mixed pseudo-random traffic against the model
    tag = "R1 R5 R8 mixed";
    lfsr = 16'hACE1;
    for (int i = 0; i < 5000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpu_ce    = lfsr[0] | lfsr[1];
      qtr_tick  = lfsr[4:2] == 3'd0;
      half_tick = lfsr[7:5] == 3'd0;
      chan_en   = lfsr[11:8] != 4'd0;
      wr_en     = lfsr[15:13] == 3'd0;
      wr_sel    = lfsr[9:8];
      wr_data   = {lfsr[3:0], lfsr[12:9]};
      cyc();
    end
    wr_en = 1'b0; qtr_tick = 1'b0; half_tick = 1'b0;
    run(4);

    done = 1'b1;
    report();
    $finish;
  end

endmodule